// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address by fetching entries from a two-level translation table held in ordinary memory. A requester hands over the virtual address, whether the access is a write, and whether it comes from user mode. At the moment the request is taken, the block also latches the physical base of the top-level table from the `dir_base` input. The walker talks to memory through a single word port. Reads on that port are level requests that complete on a one-cycle `mem_rvalid` pulse. A write is a single-cycle strobe.

A first-level entry does one of two things. It either points to a second-level table, or, when its large-page flag (bit 7) is set, it maps a whole 4 MB region directly. In both cases the leaf entry sets the final physical address and the attributes. Access rights are checked at every level the walk visits. When a translation succeeds, the walker writes the leaf entry back to memory with its accessed bit set, and also its dirty bit if the access is a write. This write happens only when it would change the stored word. A translation that fails comes back with a fault code and the level at which it stopped.

The walker handles one request at a time. It moves through seven named states:
- **IDLE** goes to READ_PDE when a request is accepted.
- **READ_PDE** goes to CHECK_PDE when read data returns.
- **CHECK_PDE** goes to DONE on a fault, to UPDATE_AD for a large page, and to READ_PTE otherwise.
- **READ_PTE** goes to CHECK_PTE when read data returns.
- **CHECK_PTE** goes to DONE on a fault, and to UPDATE_AD otherwise.
- **UPDATE_AD** always goes to DONE.
- **DONE** always goes back to IDLE.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high only when the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each taken request produces exactly one `rsp_valid` pulse, one cycle long.
- R2: The first read goes to address {latched `dir_base`[31:12], VA[31:22], 2'b00}, and `dir_base` is sampled when the request is taken.
- R3: If bit 0 of the first-level entry is clear, the walker reports fault code 2'b01 (absent) with `rsp_fault_lvl`=0 and makes no second read.
- R4: If a valid, permitted first-level entry has bit 7 set, the walk ends after one read, and the physical address is {entry[31:22], VA[21:0]}.
- R5: Otherwise the second read goes to {first entry[31:12], VA[21:12], 2'b00}, and the physical address is {second entry[31:12], VA[11:0]}.
- R6: If bit 0 of the second-level entry is clear, the walker reports fault code 2'b01 with `rsp_fault_lvl`=1.
- R7: At each level visited, a write to an entry whose bit 1 is 0, or a user access to an entry whose bit 2 is 0, raises fault code 2'b10 (protection), and `rsp_fault_lvl` names that level (0 first, 1 second).
- R8: Within an entry, the absent check takes priority over the protection check.
- R9: On success, the leaf entry is written back to its own address with bit 5 (accessed) set, and only if the stored word changes.
- R10: A write access also sets bit 6 (dirty) in the written-back leaf.
- R11: A faulted walk makes no memory write.
- R12: Entry bits 11..9 do not change the outcome and are carried unchanged into the written-back word.
- R13: `rsp_attr` carries bits 8..0 of the leaf as finally stored, including the updated accessed and dirty bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| dir_base | input | 32 | Physical base of the first-level table (bits 31..12 used) |
| mem_rd | output | 1 | Read request, held until read data returns |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_addr | output | 32 | Word address for a read or write |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_pa | output | 32 | Translated physical address |
| rsp_attr | output | 9 | Leaf entry bits 8..0 after the update |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_code | output | 2 | 0 none, 1 absent, 2 protection |
| rsp_fault_lvl | output | 1 | Level that faulted (0 first, 1 second) |

## Verification
The bench's memory model answers each read one cycle after it is requested. Under that model, `rsp_valid` rises a fixed number of clock edges after the accepting edge:
- 3 edges for a first-level fault,
- 4 edges for a large page,
- 6 edges for a second-level fault,
- 7 edges for a small-page success.

For every request, the bench counts edges from acceptance and compares the count with the expected value. It samples all results on the falling edge where `rsp_valid` is first seen high. It also compares the read and write counts from its memory model, which confirms that a walk stopped early and that no redundant write-back took place.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PDE,
        ST_CHECK_PDE,
        ST_READ_PTE,
        ST_CHECK_PTE,
        ST_UPDATE_AD,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_code_e;

    // Entry bit positions that the walker decodes
    localparam int BIT_VALID = 0;
    localparam int BIT_WRITE = 1;
    localparam int BIT_USER  = 2;
    localparam int BIT_ACC   = 5;
    localparam int BIT_DIRTY = 6;
    localparam int BIT_LARGE = 7;

endpackage

// File: rtl/pgwalk_check.sv
module pgwalk_check
    import pgwalk_pkg::*;
(
    input  logic [2:0]  entry_lo,
    input  logic        is_write,
    input  logic        is_user,
    output fault_code_e code
);
    logic deny;

    always_comb begin
        deny = (is_write && !entry_lo[BIT_WRITE]) || (is_user && !entry_lo[BIT_USER]);
        if (!entry_lo[BIT_VALID]) begin
            code = FLT_ABSENT;
        end else if (deny) begin
            code = FLT_PROT;
        end else begin
            code = FLT_NONE;
        end
    end
endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
    parameter int OFS_W  = 12,
    parameter int IDX_W  = 10,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-OFS_W-1:0] base_hi,
    input  logic [ADDR_W-OFS_W-1:0] pde_hi,
    input  logic [ADDR_W-OFS_W-1:0] pte_hi,
    input  logic [ADDR_W-1:0]       va,
    output logic [ADDR_W-1:0]       pde_addr,
    output logic [ADDR_W-1:0]       pte_addr,
    output logic [ADDR_W-1:0]       pa_large,
    output logic [ADDR_W-1:0]       pa_small
);
    localparam int HI_W   = ADDR_W - OFS_W;
    localparam int ENT_SH = OFS_W - IDX_W;
    localparam int LG_W   = OFS_W + IDX_W;

    logic [IDX_W-1:0] idx_top;
    logic [IDX_W-1:0] idx_mid;

    assign idx_top  = va[ADDR_W-1 -: IDX_W];
    assign idx_mid  = va[LG_W-1 -: IDX_W];
    assign pde_addr = {base_hi, idx_top, {ENT_SH{1'b0}}};
    assign pte_addr = {pde_hi, idx_mid, {ENT_SH{1'b0}}};
    assign pa_large = {pde_hi[HI_W-1 -: (ADDR_W-LG_W)], va[LG_W-1:0]};
    assign pa_small = {pte_hi, va[OFS_W-1:0]};
endmodule

// File: rtl/pgwalk_ad.sv
module pgwalk_ad
    import pgwalk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] leaf,
    input  logic         is_write,
    output logic [W-1:0] wb_data,
    output logic         need_wb
);
    always_comb begin
        wb_data = leaf;
        wb_data[BIT_ACC] = 1'b1;
        if (is_write) begin
            wb_data[BIT_DIRTY] = 1'b1;
        end
        need_wb = (wb_data != leaf);
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter  int OFS_W  = 12,
    parameter  int IDX_W  = 10,
    parameter  int ATTR_W = 9,
    localparam int ADDR_W = 2 * IDX_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic [ATTR_W-1:0] rsp_attr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_code,
    output logic              rsp_fault_lvl
);
    localparam int HI_W  = ADDR_W - OFS_W;
    localparam int N_LVL = 2;

    walk_state_e state, state_nxt;

    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic              user_q;
    logic [HI_W-1:0]   base_q;
    logic [ADDR_W-1:0] pde_q;
    logic [ADDR_W-1:0] pte_q;
    logic [ADDR_W-1:0] leaf_q;
    logic [ADDR_W-1:0] leaf_addr_q;
    logic [ADDR_W-1:0] pa_q;
    fault_code_e       code_q;
    logic              lvl_q;

    logic [ADDR_W-1:0] pde_addr, pte_addr, pa_large, pa_small;
    logic [ADDR_W-1:0] wb_data;
    logic              need_wb;
    logic [2:0]        ent_lo   [N_LVL];
    fault_code_e       lvl_code [N_LVL];
    logic              unused_base_lo;

    assign unused_base_lo = ^dir_base[OFS_W-1:0];
    assign ent_lo[0] = pde_q[2:0];
    assign ent_lo[1] = pte_q[2:0];

    // One permission/presence checker per table level
    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        pgwalk_check u_check (
            .entry_lo (ent_lo[g]),
            .is_write (wr_q),
            .is_user  (user_q),
            .code     (lvl_code[g])
        );
    end

    pgwalk_addr #(.OFS_W(OFS_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_addr (
        .base_hi  (base_q),
        .pde_hi   (pde_q[ADDR_W-1:OFS_W]),
        .pte_hi   (pte_q[ADDR_W-1:OFS_W]),
        .va       (va_q),
        .pde_addr (pde_addr),
        .pte_addr (pte_addr),
        .pa_large (pa_large),
        .pa_small (pa_small)
    );

    pgwalk_ad #(.W(ADDR_W)) u_ad (
        .leaf     (leaf_q),
        .is_write (wr_q),
        .wb_data  (wb_data),
        .need_wb  (need_wb)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      if (req_valid) state_nxt = ST_READ_PDE;
            ST_READ_PDE:  if (mem_rvalid) state_nxt = ST_CHECK_PDE;
            ST_CHECK_PDE: begin
                if (lvl_code[0] != FLT_NONE) begin
                    state_nxt = ST_DONE;
                end else if (pde_q[BIT_LARGE]) begin
                    state_nxt = ST_UPDATE_AD;
                end else begin
                    state_nxt = ST_READ_PTE;
                end
            end
            ST_READ_PTE:  if (mem_rvalid) state_nxt = ST_CHECK_PTE;
            ST_CHECK_PTE: begin
                if (lvl_code[1] != FLT_NONE) begin
                    state_nxt = ST_DONE;
                end else begin
                    state_nxt = ST_UPDATE_AD;
                end
            end
            ST_UPDATE_AD: state_nxt = ST_DONE;
            ST_DONE:      state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // Walk datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            wr_q        <= 1'b0;
            user_q      <= 1'b0;
            base_q      <= '0;
            pde_q       <= '0;
            pte_q       <= '0;
            leaf_q      <= '0;
            leaf_addr_q <= '0;
            pa_q        <= '0;
            code_q      <= FLT_NONE;
            lvl_q       <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        wr_q   <= req_write;
                        user_q <= req_user;
                        base_q <= dir_base[ADDR_W-1:OFS_W];
                        code_q <= FLT_NONE;
                        lvl_q  <= 1'b0;
                        leaf_q <= '0;
                        pa_q   <= '0;
                    end
                end
                ST_READ_PDE: begin
                    if (mem_rvalid) pde_q <= mem_rdata;
                end
                ST_CHECK_PDE: begin
                    if (lvl_code[0] != FLT_NONE) begin
                        code_q <= lvl_code[0];
                        lvl_q  <= 1'b0;
                    end else if (pde_q[BIT_LARGE]) begin
                        leaf_q      <= pde_q;
                        leaf_addr_q <= pde_addr;
                        pa_q        <= pa_large;
                    end
                end
                ST_READ_PTE: begin
                    if (mem_rvalid) pte_q <= mem_rdata;
                end
                ST_CHECK_PTE: begin
                    if (lvl_code[1] != FLT_NONE) begin
                        code_q <= lvl_code[1];
                        lvl_q  <= 1'b1;
                    end else begin
                        leaf_q      <= pte_q;
                        leaf_addr_q <= pte_addr;
                        pa_q        <= pa_small;
                    end
                end
                ST_UPDATE_AD: leaf_q <= wb_data;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready      = 1'b0;
        mem_rd         = 1'b0;
        mem_wr         = 1'b0;
        mem_addr       = '0;
        mem_wdata      = wb_data;
        rsp_valid      = 1'b0;
        rsp_pa         = pa_q;
        rsp_attr       = leaf_q[ATTR_W-1:0];
        rsp_fault      = (code_q != FLT_NONE);
        rsp_fault_code = code_q;
        rsp_fault_lvl  = lvl_q;
        unique case (state)
            ST_IDLE:      req_ready = 1'b1;
            ST_READ_PDE:  begin mem_rd = 1'b1; mem_addr = pde_addr; end
            ST_READ_PTE:  begin mem_rd = 1'b1; mem_addr = pte_addr; end
            ST_UPDATE_AD: begin mem_wr = need_wb; mem_addr = leaf_addr_q; end
            ST_DONE:      rsp_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
    parameter int OFS_W = 12,
    parameter int IDX_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [OFS_W+IDX_W-1:0] req_va_lo,
    input logic                   req_write,
    input logic                   mem_rd,
    input logic                   mem_wr,
    input logic [1:0]             wb_da,
    input logic                   rsp_valid,
    input logic [OFS_W+IDX_W-1:0] rsp_pa_lo,
    input logic                   rsp_large,
    input logic                   rsp_fault,
    input logic [1:0]             rsp_fault_code
);
    logic [OFS_W+IDX_W-1:0] seen_va;
    logic                   seen_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_va <= '0;
            seen_wr <= 1'b0;
        end else if (req_valid && req_ready) begin
            seen_va <= req_va_lo;
            seen_wr <= req_write;
        end
    end

    AST_NO_RDWR:   assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));                  // R9
    AST_RDY_RSP:   assert property (@(posedge clk) disable iff (!rst_n) !(req_ready && rsp_valid));            // R1
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);             // R1
    AST_WB_OK:     assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> (rsp_valid && !rsp_fault)); // R11
    AST_WB_ACC:    assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> wb_da[0]);                  // R9
    AST_WB_DIRTY:  assert property (@(posedge clk) disable iff (!rst_n) (mem_wr && seen_wr) |-> wb_da[1]);     // R10
    AST_FLT_CODE:  assert property (@(posedge clk) disable iff (!rst_n)
                       rsp_valid |-> (rsp_fault_code != 2'd3 && rsp_fault == (rsp_fault_code != 2'd0)));      // R7
    AST_PA_OFS:    assert property (@(posedge clk) disable iff (!rst_n)
                       (rsp_valid && !rsp_fault) |-> rsp_pa_lo[OFS_W-1:0] == seen_va[OFS_W-1:0]);              // R5
    AST_LARGE_OFS: assert property (@(posedge clk) disable iff (!rst_n)
                       (rsp_valid && !rsp_fault && rsp_large) |-> rsp_pa_lo == seen_va);                     // R4
endmodule

bind pgwalk_top pgwalk_chk #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_va_lo      (req_va[OFS_W+IDX_W-1:0]),
    .req_write      (req_write),
    .mem_rd         (mem_rd),
    .mem_wr         (mem_wr),
    .wb_da          (mem_wdata[6:5]),
    .rsp_valid      (rsp_valid),
    .rsp_pa_lo      (rsp_pa[OFS_W+IDX_W-1:0]),
    .rsp_large      (rsp_attr[7]),
    .rsp_fault      (rsp_fault),
    .rsp_fault_code (rsp_fault_code)
);

// File: tb/sim_pgwalk_top.sv
`timescale 1ns/100ps
module sim_pgwalk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] dir_base = 32'h0001_0000;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [8:0]  rsp_attr;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_code;
    logic        rsp_fault_lvl;

    always #2.5 clk = ~clk;

    pgwalk_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .rsp_fault(rsp_fault),
        .rsp_fault_code(rsp_fault_code), .rsp_fault_lvl(rsp_fault_lvl)
    );

    // Bench memory: small aliased array, one-cycle read latency
    logic [31:0] mem [0:127];
    int          nreads = 0;
    int          nwrites = 0;
    logic        pl_en = 1'b0;
    logic [31:0] pl_addr = '0, pl_data = '0;

    function automatic int midx(input logic [31:0] a);
        return int'({a[18:16], a[5:2]});
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
        end else begin
            mem_rvalid <= mem_rd && !mem_rvalid;
            if (mem_rd && !mem_rvalid) begin
                mem_rdata <= mem[midx(mem_addr)];
                nreads    <= nreads + 1;
            end
        end
        if (mem_wr) begin
            mem[midx(mem_addr)] <= mem_wdata;
            nwrites <= nwrites + 1;
        end
        if (pl_en) mem[midx(pl_addr)] <= pl_data;
    end

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic [1:0]  code;
        logic        lvl;
        logic [31:0] pa;
        logic [3:0]  lat;
        logic        wb;
        logic [31:0] wdata;
        logic [8:0]  attr;
        logic        prio;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_0ABC, 1'b0, 1'b1, 2'd0, 1'b0, 32'h1234_5ABC, 4'd7, 1'b1, 32'h1234_5027, 9'h027, 1'b0},
        '{32'h0040_0ABC, 1'b0, 1'b1, 2'd0, 1'b0, 32'h1234_5ABC, 4'd7, 1'b0, 32'h0,         9'h027, 1'b0},
        '{32'h0040_0FF0, 1'b1, 1'b1, 2'd0, 1'b0, 32'h1234_5FF0, 4'd7, 1'b1, 32'h1234_5067, 9'h067, 1'b0},
        '{32'h0040_1010, 1'b1, 1'b0, 2'd2, 1'b1, 32'h0,         4'd6, 1'b0, 32'h0,         9'h000, 1'b0},
        '{32'h0040_1010, 1'b0, 1'b1, 2'd2, 1'b1, 32'h0,         4'd6, 1'b0, 32'h0,         9'h000, 1'b0},
        '{32'h0040_1010, 1'b0, 1'b0, 2'd0, 1'b0, 32'h2222_2010, 4'd7, 1'b1, 32'h2222_2021, 9'h021, 1'b0},
        '{32'h0040_2000, 1'b1, 1'b1, 2'd1, 1'b1, 32'h0,         4'd6, 1'b0, 32'h0,         9'h000, 1'b1},
        '{32'h0040_3444, 1'b1, 1'b1, 2'd0, 1'b0, 32'h3333_3444, 4'd7, 1'b0, 32'h0,         9'h067, 1'b0},
        '{32'h0040_4008, 1'b1, 1'b0, 2'd0, 1'b0, 32'h4444_4008, 4'd7, 1'b1, 32'h4444_4E67, 9'h067, 1'b0},
        '{32'h0080_0000, 1'b0, 1'b0, 2'd1, 1'b0, 32'h0,         4'd3, 1'b0, 32'h0,         9'h000, 1'b0},
        '{32'h00C1_2345, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0C01_2345, 4'd4, 1'b1, 32'h0C00_00E3, 9'h0E3, 1'b0},
        '{32'h00C0_0004, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0,         4'd3, 1'b0, 32'h0,         9'h000, 1'b0},
        '{32'h0100_0000, 1'b1, 1'b0, 2'd2, 1'b0, 32'h0,         4'd3, 1'b0, 32'h0,         9'h000, 1'b0},
        '{32'h0100_0000, 1'b0, 1'b0, 2'd0, 1'b0, 32'h5555_5000, 4'd7, 1'b1, 32'h5555_5027, 9'h027, 1'b0},
        '{32'h0140_0000, 1'b1, 1'b1, 2'd1, 1'b0, 32'h0,         4'd3, 1'b0, 32'h0,         9'h000, 1'b1}
    };

    int checks = 0;
    int fails  = 0;
    int got_lat, got_reads, got_writes;
    logic got_mid_ready;
    logic [31:0] got_pa, got_wdata;
    logic [8:0]  got_attr;
    logic        got_fault, got_lvl;
    logic [1:0]  got_code;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] va, input logic wr, input logic usr);
        int r0, w0, n;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
        r0 = nreads; w0 = nwrites;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_mid_ready = req_ready;
        n = 0;
        while (!rsp_valid && n < 40) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (mem_wr) got_wdata = mem_wdata;
        end
        got_lat = n; got_pa = rsp_pa; got_attr = rsp_attr; got_fault = rsp_fault;
        got_code = rsp_fault_code; got_lvl = rsp_fault_lvl;
        got_reads = nreads - r0; got_writes = nwrites - w0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        poke(32'h0001_0004, 32'h0002_0007);
        poke(32'h0001_0008, 32'h0000_0000);
        poke(32'h0001_000C, 32'h0C00_0083);
        poke(32'h0001_0010, 32'h0003_0001);
        poke(32'h0001_0014, 32'h0000_0006);
        poke(32'h0002_0000, 32'h1234_5007);
        poke(32'h0002_0004, 32'h2222_2001);
        poke(32'h0002_0008, 32'h0000_0000);
        poke(32'h0002_000C, 32'h3333_3067);
        poke(32'h0002_0010, 32'h4444_4E27);
        poke(32'h0003_0000, 32'h5555_5007);
        poke(32'h0005_0004, 32'h0AC0_00A7);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready after reset", 32'(req_ready), 32'd1);
        chk("R1 no rsp after reset", 32'(rsp_valid), 32'd0);
        chk("R1 no mem access after reset", 32'({mem_rd, mem_wr}), 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string ftag;
            v = VECS[i];
            got_wdata = '0;
            do_req(v.va, v.wr, v.usr);
            chk("R1 busy drops ready", 32'(got_mid_ready), 32'd0);
            if (v.prio) ftag = "R8 fault code";
            else if (v.code == 2'd2) ftag = "R7 fault code";
            else if (v.code == 2'd1 && !v.lvl) ftag = "R3 fault code";
            else if (v.code == 2'd1) ftag = "R6 fault code";
            else ftag = "R5 no fault";
            chk(ftag, 32'({got_fault, got_code, got_lvl}), 32'({v.code != 2'd0, v.code, v.lvl}));
            chk("R1 latency", got_lat, 32'(v.lat));
            chk("R2 read count", got_reads, (v.lat <= 4) ? 32'd1 : 32'd2);
            if (v.code != 2'd0) begin
                chk("R11 no write on fault", got_writes, 32'd0);
            end else begin
                chk(v.lat == 4 ? "R4 large pa" : "R5 small pa", got_pa, v.pa);
                chk("R9 write-back count", got_writes, 32'(v.wb));
                if (v.wb) chk(v.wr ? "R10 dirty write-back" : "R9 accessed write-back", got_wdata, v.wdata);
                chk("R13 attributes", 32'(got_attr), 32'(v.attr));
            end
        end

        // R12: ignored bits kept in stored entry
        chk("R12 stored entry", mem[midx(32'h0002_0010)], 32'h4444_4E67);
        // R9: the earlier write-backs landed
        chk("R9 stored entry", mem[midx(32'h0002_0000)], 32'h1234_5067);

        // R2: new directory base latched at acceptance
        dir_base = 32'h0005_0000;
        do_req(32'h0041_2345, 1'b0, 1'b1);
        dir_base = 32'h0001_0000;
        chk("R2 new base pa", got_pa, 32'h0AC1_2345);
        chk("R2 new base fault", 32'(got_fault), 32'd0);
        chk("R4 large latency", got_lat, 32'd4);
        chk("R9 no redundant write", got_writes, 32'd0);
        chk("R13 large attributes", 32'(got_attr), 32'h0A7);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule